// File: doc/BRIEF.md
# Byte-wide parallel bus slave bridge

This block is the device-side target of an 8-bit parallel bus driven by a host. The host supplies the bus clock, two phase strobes (one marking address bytes, one marking data bytes) and a level that selects the access direction. The block collects two address bytes into a 16-bit word address. It then turns each group of four data bytes into one 32-bit access on a plain internal register port. That port carries an address, write data, a one-cycle write strobe, a one-cycle read strobe and read data. Every part of the block runs on the bus clock. Bus inputs are sampled on the falling edge, and outgoing read bytes change on the rising edge.

During a read, the first data cycle of each word is a fetch cycle. In that cycle the block pulses the read strobe and loads the returned word. The next four data cycles present the word on the data lines, most significant byte first. During a write, the four bytes are gathered and the write strobe pulses once the last byte has been sampled. Once a word completes, the word address steps up by one, so back-to-back words in a burst go to consecutive addresses. A new address phase cancels any partial word.

The data lines leave the block as a separate input, output and output-enable, ready for a pad cell. The output enable is high only while the host is reading data.

Top module: `bytebus_bridge`

## Requirements
- R1: While reset is held, and with both strobes low, reg_wr, reg_rd and bus_d_oe are low and reg_addr is 0x0000.
- R2: On each falling edge with addr_sel high, bus_d_in shifts into reg_addr from the low end, so the first of two address bytes becomes the high byte. addr_sel has priority over data_sel.
- R3: With data_sel and wr_en high, four sampled bytes form reg_wdata, most significant byte first. reg_wr is high for exactly one cycle from the falling edge that samples the fourth byte, and reg_addr holds the word address throughout.
- R4: The first data_sel cycle of a word with wr_en low is a fetch cycle: reg_rd pulses for one cycle at the current reg_addr. In the next four data_sel cycles, bus_d_out carries reg_rdata bits 31:24, 23:16, 15:8 and 7:0, each byte changing on a rising edge.
- R5: After each completed word, in either direction, reg_addr increases by one. A burst of N words therefore reaches N consecutive addresses, with one strobe per word and no strobe for an address that was not requested.
- R6: An address phase in the middle of a word discards the partial word. No strobe is issued for it, and the next four data bytes form a complete word at the new address.
- R7: bus_d_oe is high only while data_sel is high and wr_en is low. It is low during address phases, write phases and idle cycles.
- R8: Incrementing from address 0xFFFF wraps to 0x0000.
- R9: A cycle with data_sel low inside a word does not advance the byte position or produce a strobe. The word resumes at the next data_sel cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Marks the current byte as an address byte |
| data_sel | input | 1 | Marks the current byte as a data byte |
| wr_en | input | 1 | High for write, low for read |
| bus_d_in | input | 8 | Byte from the data lines |
| bus_d_out | output | 8 | Byte to the data lines |
| bus_d_oe | output | 1 | Output enable for the data lines |
| reg_addr | output | 16 | Word address on the register port |
| reg_wdata | output | 32 | Write word on the register port |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read word, valid while reg_rd is high |

## Verification
The embedded properties are checked on every falling edge. They cover the following: both strobes last a single cycle and never overlap; the address holds steady under a write strobe and steps by one afterwards; a read strobe only follows a read data cycle; each address byte lands in the low byte of the address. The bench scenarios are needed for the rest. These are the byte order on the data lines, the values returned across multi-word bursts, cancelling a partial word with a new address, pausing mid-word with data_sel low, the wrap at the top of the address space, and the output enable seen across the different phases.

// File: rtl/bytebus_bridge.sv
module bytebus_bridge #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          bus_clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          data_sel,
  input  logic          wr_en,
  input  logic [BW-1:0] bus_d_in,
  output logic [BW-1:0] bus_d_out,
  output logic          bus_d_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NB = DW / BW;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [CW-1:0] byte_cnt;
  logic          fetched;
  logic          rd_byte;
  logic [DW-1:0] wbuf;
  logic [DW-1:0] shreg;
  logic          last_byte;

  assign last_byte = (byte_cnt == CW'(NB - 1));
  assign reg_wdata = wbuf;
  assign bus_d_out = shreg[DW-1 -: BW];
  assign bus_d_oe  = data_sel & ~wr_en;

  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr <= '0;
      byte_cnt <= '0;
      fetched  <= 1'b0;
      rd_byte  <= 1'b0;
      wbuf     <= '0;
      reg_wr   <= 1'b0;
      reg_rd   <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_byte <= 1'b0;
      if (addr_sel) begin
        reg_addr <= {reg_addr[AW-BW-1:0], bus_d_in};
        byte_cnt <= '0;
        fetched  <= 1'b0;
      end else begin
        if (reg_wr)
          reg_addr <= reg_addr + AW'(1);
        if (data_sel) begin
          if (wr_en) begin
            wbuf     <= {wbuf[DW-BW-1:0], bus_d_in};
            byte_cnt <= byte_cnt + CW'(1);
            fetched  <= 1'b0;
            if (last_byte)
              reg_wr <= 1'b1;
          end else if (!fetched) begin
            reg_rd  <= 1'b1;
            fetched <= 1'b1;
          end else begin
            rd_byte  <= 1'b1;
            byte_cnt <= byte_cnt + CW'(1);
            if (last_byte) begin
              fetched  <= 1'b0;
              reg_addr <= reg_addr + AW'(1);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (reg_rd)
      shreg <= reg_rdata;
    else if (rd_byte)
      shreg <= {shreg[DW-BW-1:0], {BW{1'b0}}};
  end

  // R3
  wr_pulse_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4
  rd_pulse_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R5
  strobe_excl_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R3
  wr_addr_hold_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_addr));

  // R5
  wr_addr_step_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (reg_wr && !addr_sel) |=> (reg_addr == AW'($past(reg_addr) + AW'(1))));

  // R4
  rd_cause_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    reg_rd |-> $past(data_sel && !wr_en && !addr_sel));

  // R2
  addr_byte_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    addr_sel |=> (reg_addr[BW-1:0] == $past(bus_d_in)));
endmodule

// File: tb/bytebus_bridge_tb_top.sv
module bytebus_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_sel = 1'b0, data_sel = 1'b0, wr_en = 1'b0;
  logic [7:0]  d_in = 8'h00;
  logic [7:0]  d_out;
  logic        d_oe;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] last_wa = '0;
  logic [31:0] last_wd = '0;
  logic [7:0]  seen_d;
  logic        seen_oe;
  bit          done = 0;

  always #10 clk = ~clk;

  bytebus_bridge dut_i (
    .bus_clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .data_sel(data_sel),
    .wr_en(wr_en), .bus_d_in(d_in), .bus_d_out(d_out), .bus_d_oe(d_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] word_at(logic [15:0] a);
    return {a ^ 16'hA5C3, a + 16'h1234};
  endfunction

  assign reg_rdata = word_at(reg_addr);

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
    end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic as, logic ds, logic we, logic [7:0] d);
    @(posedge clk);
    #2;
    addr_sel = as; data_sel = ds; wr_en = we; d_in = d;
    #6;
    seen_d = d_out;
    seen_oe = d_oe;
    @(negedge clk);
    #2;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7 idle oe", 32'(seen_oe), 32'd0);
  endtask

  task automatic send_addr(logic [15:0] a);
    cyc(1'b1, 1'b0, 1'b0, a[15:8]);
    chk("R7 addr phase oe", 32'(seen_oe), 32'd0);
    cyc(1'b1, 1'b0, 1'b0, a[7:0]);
    chk("R2 address", 32'(reg_addr), 32'(a));
  endtask

  task automatic write_word(logic [31:0] w, logic [15:0] a);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1, 1'b1, w[31-8*i -: 8]);
      chk("R7 write phase oe", 32'(seen_oe), 32'd0);
      if (i < 3) chk("R3 no early strobe", 32'(reg_wr), 32'd0);
    end
    chk("R3 write strobe", 32'(reg_wr), 32'd1);
    chk("R3 write data", reg_wdata, w);
    chk("R5 write address", 32'(reg_addr), 32'(a));
  endtask

  task automatic read_word(logic [15:0] a);
    logic [31:0] exp;
    exp = word_at(a);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R4 read strobe", 32'(reg_rd), 32'd1);
    chk("R5 read address", 32'(reg_addr), 32'(a));
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      if (i == 0) chk("R4 strobe one cycle", 32'(reg_rd), 32'd0);
      chk("R7 read oe", 32'(seen_oe), 32'd1);
      chk("R4 read byte", 32'(seen_d), 32'(exp[31-8*i -: 8]));
    end
  endtask

  localparam logic [47:0] WR_VEC [5] = '{
    {16'h0010, 32'h1234_5678},
    {16'h3A5C, 32'h0000_0001},
    {16'h8001, 32'h8000_0000},
    {16'hC0DE, 32'hFFFF_FFFF},
    {16'h0F0F, 32'hA55A_3CC3}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base_w, base_r;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset reg_wr", 32'(reg_wr), 32'd0);
    chk("R1 reset reg_rd", 32'(reg_rd), 32'd0);
    chk("R1 reset addr", 32'(reg_addr), 32'd0);
    chk("R1 reset oe", 32'(d_oe), 32'd0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    idle();

    for (int v = 0; v < 5; v++) begin
      logic [15:0] a;
      logic [31:0] w;
      {a, w} = WR_VEC[v];
      base_w = wr_cnt;
      send_addr(a);
      write_word(w, a);
      idle();
      chk("R3 strobe ends", 32'(reg_wr), 32'd0);
      chk("R3 written word", last_wd, w);
      chk("R3 written address", 32'(last_wa), 32'(a));
      chk("R5 one strobe per word", 32'(wr_cnt - base_w), 32'd1);
      chk("R5 address after write", 32'(reg_addr), 32'(a + 16'd1));
    end

    base_r = rd_cnt;
    send_addr(16'h0A17);
    read_word(16'h0A17);
    idle();
    idle();
    chk("R5 address after read", 32'(reg_addr), 32'h0A18);
    chk("R5 no extra read", 32'(rd_cnt - base_r), 32'd1);

    send_addr(16'h2300);
    for (int i = 0; i < 3; i++) write_word(32'hB0B0_0000 + 32'(i), 16'h2300 + 16'(i));
    idle();
    chk("R5 burst last address", 32'(last_wa), 32'h2302);

    base_r = rd_cnt;
    send_addr(16'h7FFE);
    for (int i = 0; i < 3; i++) read_word(16'h7FFE + 16'(i));
    idle();
    chk("R5 burst read count", 32'(rd_cnt - base_r), 32'd3);

    send_addr(16'h1111);
    cyc(1'b0, 1'b1, 1'b1, 8'hEE);
    cyc(1'b0, 1'b1, 1'b1, 8'hDD);
    base_w = wr_cnt;
    send_addr(16'h2222);
    chk("R6 no strobe on abort", 32'(reg_wr), 32'd0);
    write_word(32'h0102_0304, 16'h2222);
    idle();
    chk("R6 single strobe", 32'(wr_cnt - base_w), 32'd1);
    chk("R6 clean word", last_wd, 32'h0102_0304);

    send_addr(16'h4444);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    send_addr(16'h5555);
    read_word(16'h5555);
    idle();

    base_w = wr_cnt;
    send_addr(16'h6060);
    cyc(1'b0, 1'b1, 1'b1, 8'h9A);
    cyc(1'b0, 1'b1, 1'b1, 8'hBC);
    idle();
    chk("R9 no strobe in pause", 32'(reg_wr), 32'd0);
    cyc(1'b0, 1'b1, 1'b1, 8'hDE);
    cyc(1'b0, 1'b1, 1'b1, 8'hF0);
    chk("R9 strobe after resume", 32'(reg_wr), 32'd1);
    chk("R9 resumed word", reg_wdata, 32'h9ABC_DEF0);
    idle();
    chk("R9 one strobe", 32'(wr_cnt - base_w), 32'd1);

    send_addr(16'h6161);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R9 read byte0", 32'(seen_d), 32'(word_at(16'h6161) >> 24));
    idle();
    chk("R9 read pause oe", 32'(seen_oe), 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R9 no refetch", 32'(reg_rd), 32'd0);
    chk("R9 read byte1", 32'(seen_d), 32'(word_at(16'h6161) >> 16) & 32'hFF);

    send_addr(16'hFFFF);
    write_word(32'h5151_5151, 16'hFFFF);
    write_word(32'h6262_6262, 16'h0000);
    idle();
    chk("R8 wrapped address", 32'(last_wa), 32'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule